// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port with Alternate Functions

An eight-bit general-purpose I/O port. Each pin is backed by an output latch. There is no direction register: a latch bit at 0 pulls its pin hard low. A latch bit at 1 releases the pin, so an outside source or the block's own alternate-function logic can set its level. Software that wants to read a pin as an input must first write a one to that bit.

The CPU side has four operations:
- a latch write;
- a read-modify-write whose source operand is always the latch, never the pin;
- a read-latch strobe, which returns the flip-flop contents;
- a read-pin strobe, which returns the synchronized pad level.

Each bit also has an alternate-function output and an alternate-function input tap. The alternate output is wired-AND with the latch. The alternate input only passes the pin through while the latch holds a one.

A variant input selects between two port types:
- **Pull-up variant.** A released pin is held high by a weak pull-up.
- **Open-drain variant.** A released pin floats. This variant can also carry an external-memory address/data phase. During that phase it drives the bus push-pull and loads its latch with all ones.

Top module: `quasi_bidir_port`

## Requirements
- R1: While reset is asserted and after its release, every latch bit holds 1, `rd_data` is 0, and `drv_low` is 0 while `alt_out` is all ones.
- R2: A `wr_en` cycle loads `wr_data` into the latch. A read-latch strobe puts the latch contents on `rd_data` one clock later, whatever level the pins carry.
- R3: A read-pin strobe puts the pin level on `rd_data` one clock later, after a two-stage synchronizer, so the pin must be stable for two clocks before the strobe. When both read strobes are high in the same cycle, the pin read wins. `rd_data` holds when no strobe is high.
- R4: Outside an external-memory phase, `drv_low[i]` is 1 exactly when latch bit i is 0 or `alt_out[i]` is 0 (wired-AND). This is combinational.
- R5: In the pull-up variant (`variant_sel`=0), `drv_high[i]` is the complement of `drv_low[i]`. In the open-drain variant (`variant_sel`=1), `drv_high` is 0 outside an external-memory phase, so a released pin floats.
- R6: A bit whose latch is 1 and whose `alt_out` is 1 does not load its pin, so a read-pin access returns the external level. A bit whose latch is 0 reads 0.
- R7: `alt_in[i]` equals the synchronized pin level ANDed with latch bit i. It reads 0, which means blocked, while the latch bit is 0.
- R8: `rmw_en` updates the latch from the latch value and `rmw_mask` using `rmw_op`: 0 = AND, 1 = OR, 2 = XOR, 3 = complement (the mask is ignored). The result appears one clock later.
- R9: With `variant_sel`=1 and `ext_en`=1, pins are driven with `ext_wdata` (`drv_low` = ~`ext_wdata`, `drv_high` = `ext_wdata`) when `ext_dir_out`=1, and are all released (both 0) when `ext_dir_out`=0. The latch is loaded with all ones at each clock of the phase. `wr_en` and `rmw_en` are ignored during the phase.
- R10: With `variant_sel`=0, `ext_en` has no effect on the drivers or the latch.
- R11: When `wr_en` and `rmw_en` are both high, the write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_sel | input | 1 | 0 = pull-up variant, 1 = open-drain address/data variant |
| wr_en | input | 1 | Latch write |
| wr_data | input | 8 | Latch write value |
| rmw_en | input | 1 | Read-modify-write on the latch |
| rmw_op | input | 2 | 0 AND, 1 OR, 2 XOR, 3 complement |
| rmw_mask | input | 8 | Operand for read-modify-write |
| rd_latch_stb | input | 1 | Read the latch |
| rd_pin_stb | input | 1 | Read the pins |
| rd_data | output | 8 | Registered read result |
| alt_out | input | 8 | Alternate-function output per bit |
| alt_in | output | 8 | Alternate-function input tap per bit |
| ext_en | input | 1 | External-memory phase active |
| ext_dir_out | input | 1 | 1 = phase drives address/data onto the pins |
| ext_wdata | input | 8 | Address/data value driven during the phase |
| pin_in | input | 8 | Pad level |
| drv_low | output | 8 | Strong-low driver enable |
| drv_high | output | 8 | Pull-up or high-drive enable |

## Verification
Driver outputs (`drv_low`, `drv_high`) are combinational from the latch and the alternate and external inputs. They are therefore checked at the falling edge after the clock that updated the latch. Latch writes and read-modify-writes show on a read-latch strobe one clock after that strobe. Pin reads and `alt_in` depend on the two synchronizer stages, so the bench lets every pin change sit through two rising edges before it issues a read-pin strobe or samples `alt_in`. The bench then compares `rd_data` one clock after the strobe. The bench resolves each pad as the external level ANDed with the inverse of `drv_low`, which is how the pin-versus-latch difference becomes visible.

// File: rtl/port_pkg.sv
package port_pkg;
    typedef enum logic [1:0] {
        RMW_AND = 2'd0,
        RMW_OR  = 2'd1,
        RMW_XOR = 2'd2,
        RMW_NOT = 2'd3
    } rmw_op_e;

    typedef enum logic {
        VAR_PULLUP     = 1'b0,
        VAR_OPEN_DRAIN = 1'b1
    } port_variant_e;
endpackage

// File: rtl/port_pin_sync.sv
module port_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] pin_sync
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = pin_raw;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign pin_sync = st_q.stage[LAST];
endmodule

// File: rtl/port_latch_ctl.sv
module port_latch_ctl
    import port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_hold,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_en,
    input  logic [1:0]       rmw_op,
    input  logic [WIDTH-1:0] rmw_mask,
    output logic [WIDTH-1:0] latch_q
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } latch_state_t;

    latch_state_t st_d, st_q;
    rmw_op_e      op;

    assign op = rmw_op_e'(rmw_op);

    always_comb begin
        st_d = st_q;
        if (ext_hold) begin
            st_d.bits = '1;
        end else if (wr_en) begin
            st_d.bits = wr_data;
        end else if (rmw_en) begin
            unique case (op)
                RMW_AND: st_d.bits = st_q.bits & rmw_mask;
                RMW_OR:  st_d.bits = st_q.bits | rmw_mask;
                RMW_XOR: st_d.bits = st_q.bits ^ rmw_mask;
                RMW_NOT: st_d.bits = ~st_q.bits;
                default: st_d.bits = st_q.bits;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{bits: '1};
        else        st_q <= st_d;
    end

    assign latch_q = st_q.bits;
endmodule

// File: rtl/port_pad_drive.sv
module port_pad_drive #(
    parameter int WIDTH = 8
) (
    input  logic             open_drain,
    input  logic             ext_hold,
    input  logic             ext_dir_out,
    input  logic [WIDTH-1:0] ext_wdata,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] alt_out,
    output logic [WIDTH-1:0] drv_low,
    output logic [WIDTH-1:0] drv_high
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic release_bit;
        assign release_bit = latch_q[i] & alt_out[i];
        always_comb begin
            if (ext_hold) begin
                drv_low[i]  = ext_dir_out & ~ext_wdata[i];
                drv_high[i] = ext_dir_out &  ext_wdata[i];
            end else begin
                drv_low[i]  = ~release_bit;
                drv_high[i] = ~open_drain & release_bit;
            end
        end
    end
endmodule

// File: rtl/quasi_bidir_port.sv
module quasi_bidir_port
    import port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             variant_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_en,
    input  logic [1:0]       rmw_op,
    input  logic [WIDTH-1:0] rmw_mask,
    input  logic             rd_latch_stb,
    input  logic             rd_pin_stb,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] alt_out,
    output logic [WIDTH-1:0] alt_in,
    input  logic             ext_en,
    input  logic             ext_dir_out,
    input  logic [WIDTH-1:0] ext_wdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] drv_low,
    output logic [WIDTH-1:0] drv_high
);
    typedef struct packed {
        logic [WIDTH-1:0] rd;
    } rd_state_t;

    port_variant_e    variant;
    logic             ext_hold;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pin_sync;
    rd_state_t        st_d, st_q;

    assign variant  = port_variant_e'(variant_sel);
    assign ext_hold = ext_en & (variant == VAR_OPEN_DRAIN);

    port_latch_ctl #(.WIDTH(WIDTH)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_hold (ext_hold),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rmw_en   (rmw_en),
        .rmw_op   (rmw_op),
        .rmw_mask (rmw_mask),
        .latch_q  (latch_q)
    );

    port_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_sync (pin_sync)
    );

    port_pad_drive #(.WIDTH(WIDTH)) u_pad (
        .open_drain  (variant == VAR_OPEN_DRAIN),
        .ext_hold    (ext_hold),
        .ext_dir_out (ext_dir_out),
        .ext_wdata   (ext_wdata),
        .latch_q     (latch_q),
        .alt_out     (alt_out),
        .drv_low     (drv_low),
        .drv_high    (drv_high)
    );

    always_comb begin
        st_d = st_q;
        if (rd_pin_stb)        st_d.rd = pin_sync;
        else if (rd_latch_stb) st_d.rd = latch_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd;
    assign alt_in  = pin_sync & latch_q;
endmodule

// File: rtl/quasi_bidir_port_chk.sv
module quasi_bidir_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             variant_sel,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             rd_latch_stb,
    input logic             rd_pin_stb,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] alt_out,
    input logic             ext_en,
    input logic [WIDTH-1:0] latch_q,
    input logic [WIDTH-1:0] drv_low,
    input logic [WIDTH-1:0] drv_high
);
    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_low & drv_high) == '0);

    // R5
    open_drain_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (variant_sel && !ext_en) |-> drv_high == '0);

    // R4
    wired_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(variant_sel && ext_en) |-> ((~alt_out & ~drv_low) == '0));

    // R9
    ext_sets_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (variant_sel && ext_en) |=> latch_q == {WIDTH{1'b1}});

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(variant_sel && ext_en)) |=> latch_q == $past(wr_data));

    // R2
    read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latch_stb && !rd_pin_stb) |=> rd_data == $past(latch_q));
endmodule

bind quasi_bidir_port quasi_bidir_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .variant_sel  (variant_sel),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_latch_stb (rd_latch_stb),
    .rd_pin_stb   (rd_pin_stb),
    .rd_data      (rd_data),
    .alt_out      (alt_out),
    .ext_en       (ext_en),
    .latch_q      (latch_q),
    .drv_low      (drv_low),
    .drv_high     (drv_high)
);

// File: tb/quasi_bidir_port_test.sv
module quasi_bidir_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       variant_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rmw_en = 1'b0;
    logic [1:0] rmw_op = 2'd0;
    logic [7:0] rmw_mask = 8'h00;
    logic       rd_latch_stb = 1'b0;
    logic       rd_pin_stb = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] alt_out = 8'hFF;
    logic [7:0] alt_in;
    logic       ext_en = 1'b0;
    logic       ext_dir_out = 1'b0;
    logic [7:0] ext_wdata = 8'h00;
    logic [7:0] ext_lvl = 8'hFF;
    logic [7:0] pin_in;
    logic [7:0] drv_low;
    logic [7:0] drv_high;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign pin_in = ext_lvl & ~drv_low;

    quasi_bidir_port uut (
        .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rmw_en(rmw_en), .rmw_op(rmw_op),
        .rmw_mask(rmw_mask), .rd_latch_stb(rd_latch_stb), .rd_pin_stb(rd_pin_stb),
        .rd_data(rd_data), .alt_out(alt_out), .alt_in(alt_in), .ext_en(ext_en),
        .ext_dir_out(ext_dir_out), .ext_wdata(ext_wdata), .pin_in(pin_in),
        .drv_low(drv_low), .drv_high(drv_high)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_latch(input logic [7:0] v);
        wr_data = v; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic read_latch(output logic [7:0] v);
        rd_latch_stb = 1'b1;
        tick();
        rd_latch_stb = 1'b0;
        v = rd_data;
    endtask

    task automatic read_pin(output logic [7:0] v);
        tick(); tick();
        rd_pin_stb = 1'b1;
        tick();
        rd_pin_stb = 1'b0;
        v = rd_data;
    endtask

    function automatic logic [7:0] rmw_model(input int op, input logic [7:0] l, input logic [7:0] m);
        case (op)
            0: return l & m;
            1: return l | m;
            2: return l ^ m;
            default: return ~l;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        @(negedge clk);
        tick();
        // R1: values during reset
        check("R1 rd_data in reset", rd_data, 8'h00);
        check("R1 drv_low in reset", drv_low, 8'h00);
        rst_n = 1'b1;
        tick();
        read_latch(r);
        check("R1 latch after reset", r, 8'hFF);
        check("R1 drv_low after reset", drv_low, 8'h00);

        // R2 R3 R4 R5 R6 R7: sweep every latch value in the pull-up variant
        for (int v = 0; v < 256; v++) begin
            logic [7:0] p;
            p = 8'(v) ^ 8'h5A;
            ext_lvl = p;
            write_latch(8'(v));
            check("R4 drv_low from latch", drv_low, ~8'(v));
            check("R5 pull-up drv_high", drv_high, 8'(v));
            read_latch(r);
            check("R2 read latch", r, 8'(v));
            read_pin(r);
            check("R6 read pin", r, 8'(v) & p);
            check("R7 alt_in", alt_in, 8'(v) & p);
        end

        // R4: alternate output wired-AND with latch of ones
        ext_lvl = 8'hFF;
        write_latch(8'hFF);
        for (int a = 0; a < 256; a += 17) begin
            alt_out = 8'(a);
            #1;
            check("R4 alt_out wired-AND", drv_low, ~8'(a));
        end
        alt_out = 8'hF0;
        write_latch(8'h3C);
        check("R4 both sources", drv_low, ~(8'h3C & 8'hF0));
        alt_out = 8'hFF;

        // R3: pin read wins over latch read; hold without strobe
        write_latch(8'hFF);
        ext_lvl = 8'h81;
        tick(); tick();
        rd_pin_stb = 1'b1; rd_latch_stb = 1'b1;
        tick();
        rd_pin_stb = 1'b0; rd_latch_stb = 1'b0;
        check("R3 pin read priority", rd_data, 8'h81);
        tick();
        check("R3 hold", rd_data, 8'h81);
        ext_lvl = 8'hFF;

        // R8: read-modify-write uses latch, not pin
        for (int op = 0; op < 4; op++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] l, m;
                l = 8'(8'h96 + k * 8'h35);
                m = 8'(8'hC3 ^ (k * 8'h21));
                write_latch(l);
                ext_lvl = 8'h00;
                tick(); tick();
                rmw_en = 1'b1; rmw_op = 2'(op); rmw_mask = m;
                tick();
                rmw_en = 1'b0;
                read_latch(r);
                check("R8 rmw result", r, rmw_model(op, l, m));
                ext_lvl = 8'hFF;
            end
        end

        // R11: write wins over rmw
        write_latch(8'h0F);
        wr_en = 1'b1; wr_data = 8'hA5; rmw_en = 1'b1; rmw_op = 2'd1; rmw_mask = 8'hF0;
        tick();
        wr_en = 1'b0; rmw_en = 1'b0;
        read_latch(r);
        check("R11 write priority", r, 8'hA5);

        // R5: open-drain variant floats released pins
        variant_sel = 1'b1;
        write_latch(8'h5A);
        check("R5 open-drain drv_high", drv_high, 8'h00);
        check("R5 open-drain drv_low", drv_low, 8'hA5);

        // R9: external phase drives, ignores writes, loads ones
        write_latch(8'h00);
        ext_en = 1'b1; ext_dir_out = 1'b1; ext_wdata = 8'hC3;
        wr_en = 1'b1; wr_data = 8'h12;
        #1;
        check("R9 ext drv_low", drv_low, 8'h3C);
        check("R9 ext drv_high", drv_high, 8'hC3);
        tick();
        wr_en = 1'b0;
        ext_dir_out = 1'b0;
        #1;
        check("R9 ext release low", drv_low, 8'h00);
        check("R9 ext release high", drv_high, 8'h00);
        tick();
        ext_en = 1'b0;
        read_latch(r);
        check("R9 latch ones after ext", r, 8'hFF);

        // R10: ext ignored in pull-up variant
        variant_sel = 1'b0;
        write_latch(8'h24);
        ext_en = 1'b1; ext_dir_out = 1'b1; ext_wdata = 8'hFF;
        #1;
        check("R10 drv_low unaffected", drv_low, 8'hDB);
        tick();
        ext_en = 1'b0; ext_dir_out = 1'b0;
        read_latch(r);
        check("R10 latch unaffected", r, 8'h24);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule